// File: doc/BRIEF.md
# Relocatable Standby RAM with Lockable Base

This block is a bus slave that holds a 2 KB static data array and a small control register block. The register block sits at a fixed 8-byte address. The data array appears in a 2 KB window whose base software sets at run time anywhere in a 24-bit address space. Every access is a byte or a 16-bit word, read or write. Each one is answered with a one-cycle acknowledge two clock edges after the request is taken.

The array base can only be moved while the array is stopped and the mapping is unlocked. A lock bit, set once, freezes the mapping until reset. After reset the array is stopped and mapped at zero. Software programs the base, then clears the stop bit, and only then does the array respond. A base whose top five address bits are not all equal falls outside the reachable space, and the array never decodes there. If the array window covers the register block, array accesses win and the registers are hidden.

Top module: `reloc_sram`

## Requirements
- R1: A request sampled on a rising edge while idle is acknowledged by `ack` high for exactly one cycle after the second following edge, with `rdata` valid in that cycle. A request presented while an access is in flight is dropped. Writes acknowledge with `rdata` zero.
- R2: With STOP clear, an access decodes to the array when `addr[23:11]` equals the base's bits 23:11. Words written to the array read back unchanged at that address, from the first word of the window through the last.
- R3: `size` 0 is a byte and 1 is a word. On the big-endian data bus, a byte with `addr[0]`=0 uses `[15:8]` and one with `addr[0]`=1 uses `[7:0]`. A byte write changes only its own byte. A byte read returns that byte on its own lane, with the other lane zero.
- R4: The register block starts at REG_BASE (default 24'hFFF800) and covers offsets 0 to 7. Offset 0 is the config register: bit 15 is STOP, bit 14 is LOCK, and the other bits read zero. Offset 2 is reserved. Offset 4 holds base bits 23:16 in bits 7:0. Offset 6 holds base bits 15:11 in bits 15:11, and its bits 10:0 always read zero.
- R5: After reset, STOP=1, LOCK=0 and the base is zero.
- R6: Writes to either base register take effect only while STOP=1 and LOCK=0; otherwise they are ignored.
- R7: Writing 1 to LOCK sets it. It then stays 1 until reset. Writing 0 to LOCK has no effect, while STOP remains writable.
- R8: While STOP=1, array accesses read zero, array writes are discarded, and the register block stays reachable.
- R9: If base bits 23:19 are not all equal, the array never decodes. Remapping the base to a reachable address restores access to the stored contents.
- R10: With STOP=0 and the array window covering the register block, accesses at those addresses go to the array.
- R11: The reserved offset and any address that hits neither window read zero, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Access request strobe |
| wr | input | 1 | 1 = write, 0 = read |
| size | input | 1 | 0 = byte, 1 = word |
| addr | input | 24 | Byte address |
| wdata | input | 16 | Write data, big-endian lanes |
| ack | output | 1 | One-cycle access acknowledge |
| rdata | output | 16 | Read data, valid with ack |

## Verification
A vector table runs word and byte traffic against a mapped window: the first and last words of the window, each byte lane, and addresses one word outside either edge. This separates window-match errors from lane-steering errors. Directed sequences write the base registers under every STOP/LOCK combination and show the effect by reading back through the array. They move the base into the unreachable range and back to show that the contents survive, and they place the window over the registers to show the priority. A second request during a busy cycle shows that requests are dropped while an access is in flight.

// File: rtl/reloc_sram_pkg.sv
package reloc_sram_pkg;

  typedef enum logic {
    SZ_BYTE = 1'b0,
    SZ_WORD = 1'b1
  } xfer_size_e;

  // Byte lanes of a 16-bit big-endian bus: bit 1 = [15:8], bit 0 = [7:0].
  function automatic logic [1:0] lane_mask(input logic sz, input logic a0);
    if (sz == SZ_WORD) return 2'b11;
    return a0 ? 2'b01 : 2'b10;
  endfunction

  function automatic logic [15:0] lane_bits(input logic [1:0] lanes);
    return {{8{lanes[1]}}, {8{lanes[0]}}};
  endfunction

  // Reachable only when bits 23:19 agree (upper bits mirror bit 19).
  function automatic logic base_reachable(input logic [23:0] b);
    return (b[23:19] == 5'b00000) || (b[23:19] == 5'b11111);
  endfunction

  function automatic logic in_window(input logic [23:0] a, input logic [23:0] b,
                                     input int unsigned lsb);
    return (a >> lsb) == (b >> lsb);
  endfunction

  function automatic logic [15:0] merge16(input logic [15:0] old_v, input logic [15:0] new_v,
                                          input logic [15:0] m);
    return (old_v & ~m) | (new_v & m);
  endfunction

endpackage

// File: rtl/reloc_sram_regs.sv
module reloc_sram_regs
  import reloc_sram_pkg::*;
#(
  parameter int unsigned WIN_LSB = 11
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [1:0]  offs,
  input  logic [1:0]  lanes,
  input  logic [15:0] wdata,
  output logic [15:0] rdata,
  output logic        stop,
  output logic        lock,
  output logic [23:0] base
);
  localparam logic [15:0] LO_KEEP = 16'hFFFF << WIN_LSB;
  localparam logic [1:0]  OFF_CFG = 2'd0;
  localparam logic [1:0]  OFF_HI  = 2'd2;
  localparam logic [1:0]  OFF_LO  = 2'd3;

  logic        stop_q, lock_q;
  logic [7:0]  base_hi_q;
  logic [15:0] base_lo_q;
  logic [15:0] wmask;
  logic        base_open;

  assign wmask     = lane_bits(lanes);
  assign base_open = stop_q && !lock_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stop_q    <= 1'b1;
      lock_q    <= 1'b0;
      base_hi_q <= '0;
      base_lo_q <= '0;
    end else if (wr_en) begin
      case (offs)
        OFF_CFG: if (lanes[1]) begin
          stop_q <= wdata[15];
          if (wdata[14]) lock_q <= 1'b1;
        end
        OFF_HI: if (base_open && lanes[0]) base_hi_q <= wdata[7:0];
        OFF_LO: if (base_open) base_lo_q <= merge16(base_lo_q, wdata, wmask) & LO_KEEP;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (offs)
      OFF_CFG: rdata = {stop_q, lock_q, 14'd0};
      OFF_HI:  rdata = {8'd0, base_hi_q};
      OFF_LO:  rdata = base_lo_q;
      default: rdata = '0;
    endcase
  end

  assign stop = stop_q;
  assign lock = lock_q;
  assign base = {base_hi_q, base_lo_q};

  p_base_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(stop_q && !lock_q) |=> $stable({base_hi_q, base_lo_q}));

  p_lock_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> lock_q);

endmodule

// File: rtl/reloc_sram_decode.sv
module reloc_sram_decode
  import reloc_sram_pkg::*;
#(
  parameter int unsigned WIN_LSB  = 11,
  parameter logic [23:0] REG_BASE = 24'hFFF800
) (
  input  logic [23:0] addr,
  input  logic [23:0] base,
  input  logic        stop,
  output logic        hit_arr,
  output logic        hit_reg,
  output logic        base_ok
);
  assign base_ok = base_reachable(base);
  // Array decode takes priority over the register window.
  assign hit_arr = !stop && base_ok && in_window(addr, base, WIN_LSB);
  assign hit_reg = !hit_arr && (addr[23:3] == REG_BASE[23:3]);
endmodule

// File: rtl/reloc_sram_array.sv
module reloc_sram_array #(
  parameter int unsigned WORDS = 1024,
  localparam int unsigned IDX_W = $clog2(WORDS)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] idx,
  input  logic [1:0]       lanes,
  input  logic [15:0]      wdata,
  output logic [15:0]      rdata
);
  for (genvar g = 0; g < 2; g++) begin : g_lane
    logic [7:0] mem [WORDS];
    always_ff @(posedge clk) begin
      if (we && lanes[g]) mem[idx] <= wdata[8*g +: 8];
    end
    assign rdata[8*g +: 8] = mem[idx];
  end
endmodule

// File: rtl/reloc_sram.sv
module reloc_sram
  import reloc_sram_pkg::*;
#(
  parameter int unsigned ARRAY_BYTES = 2048,
  parameter logic [23:0] REG_BASE    = 24'hFFF800
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req,
  input  logic        wr,
  input  logic        size,
  input  logic [23:0] addr,
  input  logic [15:0] wdata,
  output logic        ack,
  output logic [15:0] rdata
);
  localparam int unsigned WIN_LSB = $clog2(ARRAY_BYTES);
  localparam int unsigned WORDS   = ARRAY_BYTES / 2;

  logic        s1_valid, s1_wr, s1_size;
  logic [23:0] s1_addr;
  logic [15:0] s1_wdata;
  logic        busy, accept;
  logic        ack_q;
  logic [15:0] rdata_q;

  logic        hit_arr, hit_reg, base_ok;
  logic        stop, lock;
  logic [23:0] base;
  logic [1:0]  lanes;
  logic        arr_we, reg_we;
  logic [15:0] arr_rd, reg_rd, sel_rd;

  assign busy   = s1_valid;
  assign accept = req && !busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_wr    <= 1'b0;
      s1_size  <= 1'b0;
      s1_addr  <= '0;
      s1_wdata <= '0;
    end else if (accept) begin
      s1_valid <= 1'b1;
      s1_wr    <= wr;
      s1_size  <= size;
      s1_addr  <= addr;
      s1_wdata <= wdata;
    end else begin
      s1_valid <= 1'b0;
    end
  end

  assign lanes  = lane_mask(s1_size, s1_addr[0]);
  assign arr_we = s1_valid && s1_wr && hit_arr;
  assign reg_we = s1_valid && s1_wr && hit_reg;

  reloc_sram_decode #(.WIN_LSB(WIN_LSB), .REG_BASE(REG_BASE)) u_decode (
    .addr(s1_addr), .base(base), .stop(stop),
    .hit_arr(hit_arr), .hit_reg(hit_reg), .base_ok(base_ok)
  );

  reloc_sram_regs #(.WIN_LSB(WIN_LSB)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_we), .offs(s1_addr[2:1]),
    .lanes(lanes), .wdata(s1_wdata), .rdata(reg_rd),
    .stop(stop), .lock(lock), .base(base)
  );

  reloc_sram_array #(.WORDS(WORDS)) u_array (
    .clk(clk), .we(arr_we), .idx(s1_addr[WIN_LSB-1:1]), .lanes(lanes),
    .wdata(s1_wdata), .rdata(arr_rd)
  );

  always_comb begin
    if (s1_wr)        sel_rd = '0;
    else if (hit_arr) sel_rd = arr_rd & lane_bits(lanes);
    else if (hit_reg) sel_rd = reg_rd & lane_bits(lanes);
    else              sel_rd = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ack_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      ack_q   <= s1_valid;
      rdata_q <= s1_valid ? sel_rd : '0;
    end
  end

  assign ack   = ack_q;
  assign rdata = rdata_q;

  p_ack_after_two_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !busy) |=> ##1 ack);

  p_ack_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack);

  p_stop_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stop |-> !arr_we);

  p_unreachable_base_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !base_reachable(base) |-> !hit_arr);

  p_one_target_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(hit_arr && hit_reg));

  // lock is observed by the assertions in u_regs; reference kept for clarity
  logic unused_ok;
  assign unused_ok = lock ^ base_ok;

endmodule

// File: tb/reloc_sram_bench.sv
module reloc_sram_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, wr = 1'b0, size = 1'b0;
  logic [23:0] addr = '0;
  logic [15:0] wdata = '0;
  logic        ack;
  logic [15:0] rdata;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  reloc_sram u_reloc_sram (
    .clk(clk), .rst_n(rst_n), .req(req), .wr(wr), .size(size),
    .addr(addr), .wdata(wdata), .ack(ack), .rdata(rdata)
  );

  typedef struct packed {
    logic        w;
    logic        sz;
    logic [23:0] a;
    logic [15:0] d;
    logic [15:0] exp;
    logic [7:0]  req_no;
  } vec_t;

  // Base programmed to 24'h012800 before this table runs; STOP cleared.
  localparam vec_t VEC [16] = '{
    '{1'b1, 1'b1, 24'h012800, 16'hA5C3, 16'h0000, 8'd2},  // R2 first word
    '{1'b1, 1'b1, 24'h012FFE, 16'h1234, 16'h0000, 8'd2},  // R2 last word
    '{1'b0, 1'b1, 24'h012800, 16'h0000, 16'hA5C3, 8'd2},
    '{1'b0, 1'b1, 24'h012FFE, 16'h0000, 16'h1234, 8'd2},
    '{1'b1, 1'b0, 24'h012801, 16'h00EE, 16'h0000, 8'd3},  // R3 low lane
    '{1'b0, 1'b1, 24'h012800, 16'h0000, 16'hA5EE, 8'd3},
    '{1'b1, 1'b0, 24'h012FFE, 16'h7700, 16'h0000, 8'd3},  // R3 high lane
    '{1'b0, 1'b1, 24'h012FFE, 16'h0000, 16'h7734, 8'd3},
    '{1'b0, 1'b0, 24'h012801, 16'h0000, 16'h00EE, 8'd3},
    '{1'b0, 1'b0, 24'h012FFE, 16'h0000, 16'h7700, 8'd3},
    '{1'b0, 1'b1, 24'h013000, 16'h0000, 16'h0000, 8'd11}, // R11 past window
    '{1'b0, 1'b1, 24'h0127FE, 16'h0000, 16'h0000, 8'd11}, // R11 before window
    '{1'b0, 1'b1, 24'hFFF800, 16'h0000, 16'h0000, 8'd4},  // R4 config
    '{1'b0, 1'b1, 24'hFFF804, 16'h0000, 16'h0001, 8'd4},
    '{1'b0, 1'b1, 24'hFFF806, 16'h0000, 16'h2800, 8'd4},
    '{1'b0, 1'b1, 24'hFFF802, 16'h0000, 16'h0000, 8'd11}  // R11 reserved
  };

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic xfer(input logic w, input logic s, input logic [23:0] a,
                      input logic [15:0] d, output logic [15:0] q);
    logic early;
    @(negedge clk);
    req = 1'b1; wr = w; size = s; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0;
    early = ack;
    @(negedge clk);
    q = rdata;
    check("R1 ack timing", {14'd0, early, ack}, 16'h0001);
  endtask

  task automatic wr16(input logic [23:0] a, input logic [15:0] d);
    logic [15:0] q;
    xfer(1'b1, 1'b1, a, d, q);
    check("R1 write data zero", q, 16'h0000);
  endtask

  task automatic rd_chk(input string tag, input logic [23:0] a, input logic [15:0] exp);
    logic [15:0] q;
    xfer(1'b0, 1'b1, a, 16'h0, q);
    check(tag, q, exp);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R1 watchdog expired actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R5 reset state
    rd_chk("R5 config", 24'hFFF800, 16'h8000);
    rd_chk("R5 base hi", 24'hFFF804, 16'h0000);
    rd_chk("R5 base lo", 24'hFFF806, 16'h0000);
    rd_chk("R8 stopped array at zero", 24'h000000, 16'h0000);

    // Map to 012800; low bits of base low are dropped (R4)
    wr16(24'hFFF804, 16'h0001);
    wr16(24'hFFF806, 16'h28FF);
    rd_chk("R4 base lo alignment", 24'hFFF806, 16'h2800);
    wr16(24'hFFF800, 16'h0000);

    for (int i = 0; i < 16; i++) begin
      logic [15:0] q;
      xfer(VEC[i].w, VEC[i].sz, VEC[i].a, VEC[i].d, q);
      check($sformatf("R%0d vector %0d", VEC[i].req_no, i), q, VEC[i].exp);
    end

    // R6 base write ignored while running
    wr16(24'hFFF804, 16'h0022);
    rd_chk("R6 base hi frozen while running", 24'hFFF804, 16'h0001);
    rd_chk("R6 array still at old base", 24'h012800, 16'hA5EE);

    // R8 stop silences array
    wr16(24'hFFF800, 16'h8000);
    rd_chk("R8 stopped read zero", 24'h012800, 16'h0000);
    wr16(24'h012800, 16'h1111);
    rd_chk("R8 registers reachable", 24'hFFF800, 16'h8000);
    wr16(24'hFFF800, 16'h0000);
    rd_chk("R8 stopped write discarded", 24'h012800, 16'hA5EE);

    // R11 reserved and unmapped
    wr16(24'hFFF802, 16'hFFFF);
    rd_chk("R11 reserved reads zero", 24'hFFF802, 16'h0000);
    wr16(24'h500000, 16'hFFFF);
    rd_chk("R11 unmapped reads zero", 24'h500000, 16'h0000);
    rd_chk("R11 unmapped write no effect", 24'h012800, 16'hA5EE);

    // R9 unreachable base, then remap back
    wr16(24'hFFF800, 16'h8000);
    wr16(24'hFFF804, 16'h0010);
    wr16(24'hFFF800, 16'h0000);
    wr16(24'h102800, 16'hBEEF);
    rd_chk("R9 unreachable never decodes", 24'h102800, 16'h0000);
    wr16(24'hFFF800, 16'h8000);
    wr16(24'hFFF804, 16'h0001);
    wr16(24'hFFF800, 16'h0000);
    rd_chk("R9 remap restores contents", 24'h012800, 16'hA5EE);

    // R10 window over registers
    wr16(24'hFFF800, 16'h8000);
    wr16(24'hFFF804, 16'h00FF);
    wr16(24'hFFF806, 16'hF800);
    wr16(24'hFFF800, 16'h0000);
    wr16(24'hFFF800, 16'hBEEF);
    rd_chk("R10 array wins over registers", 24'hFFF800, 16'hBEEF);

    do_reset();
    rd_chk("R5 config after second reset", 24'hFFF800, 16'h8000);
    rd_chk("R5 base lo after second reset", 24'hFFF806, 16'h0000);

    // R7 write-once lock
    wr16(24'hFFF800, 16'hC000);
    rd_chk("R7 lock set", 24'hFFF800, 16'hC000);
    wr16(24'hFFF800, 16'h8000);
    rd_chk("R7 lock cannot clear", 24'hFFF800, 16'hC000);
    wr16(24'hFFF804, 16'h0033);
    rd_chk("R6 base frozen when locked", 24'hFFF804, 16'h0000);
    wr16(24'hFFF800, 16'h0000);
    rd_chk("R7 stop still writable", 24'hFFF800, 16'h4000);

    // R1 request while busy is dropped
    @(negedge clk);
    req = 1'b1; wr = 1'b0; size = 1'b1; addr = 24'hFFF800;
    @(negedge clk);
    addr = 24'hFFF806;
    check("R1 no ack while busy", {15'd0, ack}, 16'h0000);
    @(negedge clk);
    req = 1'b0;
    check("R1 first ack", {15'd0, ack}, 16'h0001);
    check("R1 first data", rdata, 16'h4000);
    @(negedge clk);
    check("R1 busy request dropped", {15'd0, ack}, 16'h0000);
    @(negedge clk);
    check("R1 still idle", {15'd0, ack}, 16'h0000);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule